// File: doc/BRIEF.md
# Free-Running Stream Incrementer with Framing

This block is a streaming kernel with no start or done control. It is always ready to take data when it has room. Each accepted input beat carries a 32-bit integer. A chain of pipeline stages adds one to that value at each stage. With the default depth of ten stages, each output beat carries the input plus ten. One output beat leaves for every input beat, and the beats stay in order.

The pipeline runs freely. Interior stages have no enable: they register on every clock, and a valid bit travels alongside the data. Backpressure is absorbed by a small FIFO at the output. A credit counter lowers the input ready signal as soon as the FIFO could not take every beat that is already in flight, so no beat is ever dropped. An output-side counter counts completed handshakes and frames the stream, raising the last flag on every tenth delivered beat.

Top module: `stream_inc10_frp`

## Requirements
- R1: Each output data word equals its input word plus STAGES (default 10), wrapping modulo 2^32; for example 32'hFFFF_FFF6 gives 0 and 32'hFFFF_FFFF gives 9.
- R2: Exactly one output beat is produced for every accepted input beat, in acceptance order, and no output beat appears without an input beat.
- R3: Counting delivered output beats from 1 after reset, beat number k carries m_tlast = 1 when k is a multiple of FRAME_LEN (default 10); every other beat carries m_tlast = 0.
- R4: m_tkeep is 4'hF on every output beat.
- R5: The framing count advances only on an output handshake (m_tvalid and m_tready both high); stalled cycles and idle cycles leave it unchanged.
- R6: During and right after reset, m_tvalid is 0 and s_tready is 1, and the framing count starts at zero.
- R7: With m_tready held high, s_tready stays high and one beat per clock is accepted without a break.
- R8: With m_tready held low, exactly STAGES+FIFO_SLACK beats (default 12) are accepted before s_tready drops; none of them is lost.
- R9: While m_tvalid is high and m_tready is low, m_tvalid, m_tdata and m_tlast hold their values.
- R10: Gaps in s_tvalid need no control action; they produce no output beats and do not disturb the order or the data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat may be accepted |
| s_tdata | input | 32 | Input integer |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream accepts the output beat |
| m_tdata | output | 32 | Input integer plus STAGES |
| m_tlast | output | 1 | Marks the last beat of each group of FRAME_LEN |
| m_tkeep | output | 4 | Byte qualifiers, always all ones |

## Verification
A stage whose valid bit is wrong shows up at the output within STAGES+1 cycles. It appears as a missing beat, an extra beat, or a beat out of order against the scoreboard. A wrong credit count shows up only under backpressure. It either lets a thirteenth beat in, which then overwrites the FIFO and corrupts a later word, or it stops input early. The bench therefore counts accepted beats while the output is stalled. A framing counter that moves on stalled cycles puts m_tlast on the wrong beat within one frame. For that reason, ready is toggled while the framing is checked.

// File: rtl/inc_pkg.sv
package inc_pkg;
    localparam int WORD_W = 32;
    localparam int KEEP_W = WORD_W / 8;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic  vld;
        word_t data;
    } beat_t;
endpackage

// File: rtl/inc_stage.sv
module inc_stage
    import inc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  beat_t in_b,
    output beat_t out_b
);
    beat_t st_d, st_q;

    // free-running: no enable, valid rides along with the data
    always_comb begin
        st_d      = st_q;
        st_d.vld  = in_b.vld;
        st_d.data = in_b.data + word_t'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_b = st_q;
endmodule

// File: rtl/inc_fifo.sv
module inc_fifo
    import inc_pkg::*;
#(
    parameter int DEPTH = 12
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  word_t wr_data,
    input  logic  rd_en,
    output logic  rd_valid,
    output word_t rd_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    word_t    mem_q [DEPTH];

    function automatic logic [AW-1:0] ptr_inc(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    logic do_rd;
    assign do_rd = rd_en && (st_q.count != '0);

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.wr_ptr = ptr_inc(st_q.wr_ptr);
        if (do_rd) st_d.rd_ptr = ptr_inc(st_q.rd_ptr);
        st_d.count = st_q.count + CW'(wr_en) - CW'(do_rd);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[st_q.wr_ptr] <= wr_data;
    end

    assign rd_valid = (st_q.count != '0);
    assign rd_data  = mem_q[st_q.rd_ptr];
endmodule

// File: rtl/frame_tag.sv
module frame_tag #(
    parameter int FRAME_LEN = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_i,
    output logic last_o
);
    localparam int FW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;

    typedef struct packed {
        logic [FW-1:0] cnt;
    } tag_st_t;

    tag_st_t st_d, st_q;
    logic    at_end;

    assign at_end = (st_q.cnt == FW'(FRAME_LEN - 1));

    always_comb begin
        st_d = st_q;
        if (hs_i) st_d.cnt = at_end ? '0 : st_q.cnt + FW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign last_o = at_end;
endmodule

// File: rtl/stream_inc10_frp.sv
module stream_inc10_frp
    import inc_pkg::*;
#(
    parameter int STAGES     = 10,
    parameter int FRAME_LEN  = 10,
    parameter int FIFO_SLACK = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic [31:0]       s_tdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic [31:0]       m_tdata,
    output logic              m_tlast,
    output logic [KEEP_W-1:0] m_tkeep
);
    localparam int FIFO_DEPTH = STAGES + FIFO_SLACK;
    localparam int OCC_W      = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        logic [OCC_W-1:0] occ;
    } top_st_t;

    top_st_t st_d, st_q;
    beat_t   chain [STAGES+1];
    logic    acc, pop;

    assign s_tready = (st_q.occ < OCC_W'(FIFO_DEPTH));
    assign acc      = s_tvalid && s_tready;
    assign pop      = m_tvalid && m_tready;

    // credit: beats accepted and not yet delivered, in flight or queued
    always_comb begin
        st_d     = st_q;
        st_d.occ = st_q.occ + OCC_W'(acc) - OCC_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chain[0] = '{vld: acc, data: s_tdata};

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        inc_stage u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .in_b  (chain[g]),
            .out_b (chain[g+1])
        );
    end

    inc_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (chain[STAGES].vld),
        .wr_data  (chain[STAGES].data),
        .rd_en    (m_tready),
        .rd_valid (m_tvalid),
        .rd_data  (m_tdata)
    );

    frame_tag #(.FRAME_LEN(FRAME_LEN)) u_tag (
        .clk    (clk),
        .rst_n  (rst_n),
        .hs_i   (pop),
        .last_o (m_tlast)
    );

    assign m_tkeep = '1;
endmodule

// File: rtl/inc_chk.sv
module inc_chk #(
    parameter int FRAME_LEN = 10,
    parameter int DEPTH     = 12
) (
    input logic        clk,
    input logic        rst_n,
    input logic        s_tvalid,
    input logic        s_tready,
    input logic        m_tvalid,
    input logic        m_tready,
    input logic [31:0] m_tdata,
    input logic        m_tlast
);
    localparam int HW = $clog2(FRAME_LEN + 1) + 1;
    localparam int OW = $clog2(DEPTH + 1) + 2;

    logic [HW-1:0] hs_c;
    logic [OW-1:0] occ_c;
    logic          in_hs, out_hs;

    assign in_hs  = s_tvalid && s_tready;
    assign out_hs = m_tvalid && m_tready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_c  <= '0;
            occ_c <= '0;
        end else begin
            if (out_hs) hs_c <= (hs_c == HW'(FRAME_LEN - 1)) ? '0 : hs_c + HW'(1);
            occ_c <= occ_c + OW'(in_hs) - OW'(out_hs);
        end
    end

    // R3
    last_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_hs |-> (m_tlast == (hs_c == HW'(FRAME_LEN - 1))));

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ_c <= OW'(DEPTH));

    // R2
    no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> (occ_c != '0));

    // R7
    ready_when_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_c < OW'(DEPTH)) |-> s_tready);
endmodule

bind stream_inc10_frp inc_chk #(.FRAME_LEN(FRAME_LEN), .DEPTH(FIFO_DEPTH)) u_inc_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_tvalid (s_tvalid),
    .s_tready (s_tready),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .m_tdata  (m_tdata),
    .m_tlast  (m_tlast)
);

// File: tb/test_stream_inc10_frp.sv
module test_stream_inc10_frp;
    localparam int STAGES = 10;
    localparam int FLEN   = 10;
    localparam int DEPTH  = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic [31:0] s_tdata = '0;
    logic        m_tvalid;
    logic        m_tready;
    logic [31:0] m_tdata;
    logic        m_tlast;
    logic [3:0]  m_tkeep;

    int checks = 0;
    int errors = 0;
    int rmode  = 0;   // 0: ready high, 1: toggling, 2: ready low
    int in_cnt = 0;
    int out_cnt = 0;
    int stall_seen = 0;
    logic [31:0] exp_q [$];
    logic        prev_hold = 1'b0;
    logic [31:0] prev_data = '0;
    logic        prev_last = 1'b0;

    always #4 clk = ~clk;

    stream_inc10_frp i_stream_inc10_frp (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_tvalid (s_tvalid),
        .s_tready (s_tready),
        .s_tdata  (s_tdata),
        .m_tvalid (m_tvalid),
        .m_tready (m_tready),
        .m_tdata  (m_tdata),
        .m_tlast  (m_tlast),
        .m_tkeep  (m_tkeep)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // single driver of m_tready, changes just after the rising edge
    always @(posedge clk) begin
        #1;
        case (rmode)
            0: m_tready <= 1'b1;
            1: m_tready <= ~m_tready;
            default: m_tready <= 1'b0;
        endcase
    end
    initial m_tready = 1'b1;

    // monitor on the falling edge: values here are those seen at the next rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (s_tvalid && s_tready) begin
                exp_q.push_back(s_tdata + 32'd10);
                in_cnt++;
            end
            if (s_tvalid && !s_tready) stall_seen++;
            if (prev_hold) begin
                // R9
                check(m_tvalid && m_tdata == prev_data && m_tlast == prev_last,
                      "R9 hold", m_tdata, prev_data);
            end
            if (m_tvalid && m_tready) begin
                out_cnt++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 extra beat", m_tdata, 32'h0);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    // R1 data and R2 order
                    check(m_tdata == e, "R1/R2 data", m_tdata, e);
                end
                // R3 and R5: framing counted on handshakes only
                check(m_tlast == ((out_cnt % FLEN) == 0), "R3/R5 last", {31'b0, m_tlast},
                      {31'b0, (out_cnt % FLEN) == 0});
                // R4
                check(m_tkeep == 4'hF, "R4 keep", {28'b0, m_tkeep}, 32'hF);
            end
            prev_hold = m_tvalid && !m_tready;
            prev_data = m_tdata;
            prev_last = m_tlast;
        end
    end

    function automatic logic [31:0] lcg(input logic [31:0] x);
        return x * 32'd1664525 + 32'd1013904223;
    endfunction

    task automatic send_one(input logic [31:0] d);
        bit took;
        s_tvalid = 1'b1;
        s_tdata  = d;
        do begin
            @(negedge clk);
            took = s_tready;
            @(posedge clk);
            #1;
        end while (!took);
        s_tvalid = 1'b0;
    endtask

    task automatic send_beats(input int n, input logic [31:0] seed, input int gap);
        logic [31:0] v;
        v = seed;
        for (int i = 0; i < n; i++) begin
            send_one(v);
            v = lcg(v);
            repeat (gap) begin
                @(posedge clk);
                #1;
            end
        end
    endtask

    task automatic drain(input string req);
        int t;
        t = 0;
        while (exp_q.size() != 0 && t < 1000) begin
            @(posedge clk);
            t++;
        end
        @(posedge clk);
        #1;
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        // R6
        check(m_tvalid == 1'b0, "R6 valid in reset", {31'b0, m_tvalid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(m_tvalid == 1'b0, "R6 valid after reset", {31'b0, m_tvalid}, 0);
        check(s_tready == 1'b1, "R6 ready after reset", {31'b0, s_tready}, 1);
        @(posedge clk);
        #1;
    endtask

    task automatic t_basic;
        send_beats(20, 32'h0000_1234, 0);
        drain("R2 basic drain");
    endtask

    task automatic t_wrap;
        send_one(32'hFFFF_FFF6);
        send_one(32'hFFFF_FFFF);
        send_one(32'h7FFF_FFFF);
        send_one(32'h0000_0000);
        drain("R1 wrap drain");
    endtask

    task automatic t_throughput;
        int c0;
        stall_seen = 0;
        c0 = in_cnt;
        s_tvalid = 1'b1;
        for (int i = 0; i < 40; i++) begin
            s_tdata = 32'h100 + i;
            @(posedge clk);
            #1;
        end
        s_tvalid = 1'b0;
        // R7
        check(stall_seen == 0, "R7 no stall", stall_seen, 0);
        check(in_cnt - c0 == 40, "R7 one per clock", in_cnt - c0, 40);
        drain("R7 drain");
    endtask

    task automatic t_gaps;
        int c0;
        c0 = out_cnt;
        send_beats(15, 32'hDEAD_0000, 3);
        drain("R10 gap drain");
        // R10
        check(out_cnt - c0 == 15, "R10 beat count", out_cnt - c0, 15);
    endtask

    task automatic t_toggle;
        rmode = 1;
        send_beats(33, 32'h0BAD_F00D, 0);
        drain("R5 toggle drain");
        rmode = 0;
        @(posedge clk);
        #1;
    endtask

    task automatic t_backpressure;
        int c0;
        rmode = 2;
        repeat (3) @(posedge clk);
        #1;
        c0 = in_cnt;
        s_tvalid = 1'b1;
        for (int i = 0; i < 40; i++) begin
            s_tdata = 32'h5000 + i;
            @(posedge clk);
            #1;
        end
        // R8
        check(in_cnt - c0 == DEPTH, "R8 accepted under stall", in_cnt - c0, DEPTH);
        @(negedge clk);
        check(s_tready == 1'b0, "R8 ready low when full", {31'b0, s_tready}, 0);
        check(m_tvalid == 1'b1, "R9 valid while stalled", {31'b0, m_tvalid}, 1);
        @(posedge clk);
        #1;
        s_tvalid = 1'b0;
        rmode = 0;
        drain("R8 no loss drain");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset;
        t_basic;
        t_wrap;
        t_throughput;
        t_gaps;
        t_toggle;
        t_backpressure;
        // R2
        check(in_cnt == out_cnt, "R2 totals", out_cnt, in_cnt);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule